// File: doc/BRIEF.md
# Banked-Address Serial Port Register Block

This block is a compact asynchronous serial port with a byte-wide register window on a simple strobe bus (address, write enable, read enable, write data, registered read data). Software programs a 16-bit baud divisor, writes bytes to be sent, and polls a line status byte to learn when the transmitter can take another byte and when a received byte is waiting. Framing is fixed at one start bit, eight data bits sent least significant bit first, no parity, and one stop bit.

Two of the eight register slots are banked. Bit 7 of the line control register picks the divisor bytes or the normal data and enable registers for slots 0 and 1. The bus address is the register index shifted left by a parameter, so the block fits buses that place byte registers on 16-bit or 32-bit strides. Reading the status and data registers has side effects. A status read clears the latched receive errors, and a data read clears the data-ready flag.

A baud tick generator divides the clock by the divisor and produces sixteen ticks per bit. The transmitter double-buffers one holding byte ahead of its shift register. The receiver finds a start bit on a falling edge, confirms it at mid-bit, and samples each later bit at its centre.

Top module: `uart_lite`

## Requirements
- R1: The register index is addr[REG_SHIFT+2:REG_SHIFT]; the low REG_SHIFT address bits are ignored. Index 0 is receive data on read and transmit data on write, 1 interrupt enable, 2 identification (read) / FIFO control (write), 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch.
- R2: With line control bit 7 set, index 0 reads and writes the divisor low byte and index 1 the divisor high byte; writes there do not reach the transmit or enable registers. With bit 7 clear, index 1 reads and writes the stored interrupt enable byte.
- R3: After reset, line control, interrupt enable and divisor read 0x00, line status reads 0x60, and txd is high.
- R4: A divisor of zero produces no baud ticks, so a frame arriving on rxd is not received. A divisor N produces one tick every N clocks, and each bit lasts 16 ticks.
- R5: A transmitted frame is a low start bit, eight data bits LSB first, and a high stop bit. txd is high whenever no frame is being sent.
- R6: Line status bit 5 is 1 when the holding byte is empty. It clears on a data write and sets again when the byte moves to the shift register. Bit 6 is 1 only when both the holding byte and the shift register are empty.
- R7: A received byte is stored for index 0 and sets status bit 0. Reading index 0 with bit 7 of line control clear returns the byte and clears status bit 0.
- R8: A byte that completes while status bit 0 is still set replaces the stored byte and sets status bit 1 (overrun).
- R9: A stop bit sampled low sets status bit 3 (framing). If the byte is also all zeros, status bit 4 (break) is set as well.
- R10: Reading line status returns the bits and then clears bits 1, 3 and 4. Bits 2 and 7 always read 0.
- R11: The scratch register at index 7 stores any byte written to it and reads it back, with no other effect.
- R12: Read data appears on rd_data one clock after rd_en. Index 2 reads 0x01. Indices 4 and 6 read 0x00. Writes to indices 2, 4, 5 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Byte address, register index shifted left by REG_SHIFT |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
A read returns its value one clock after the strobe. The bench drives each strobe for one clock from the falling edge and samples rd_data at the following falling edge, so the value it sees is the one registered at the edge in between. With a divisor of 2, one bit takes 32 clocks. Only the start bit can be one clock shorter, because the tick phase is arbitrary. The transmit monitor therefore samples 16 clocks after it sees the start edge and then every 32 clocks. The receiver commits a byte at the centre of the stop bit, about 307 clocks after the start edge. The bench drives a full 320-clock frame plus an idle bit before it reads status, so every flag is settled when it is sampled.

// File: rtl/uart_lite_pkg.sv
package uart_lite_pkg;
  localparam logic [2:0] IX_DATA = 3'd0;
  localparam logic [2:0] IX_IEN  = 3'd1;
  localparam logic [2:0] IX_IDENT = 3'd2;
  localparam logic [2:0] IX_LCTL = 3'd3;
  localparam logic [2:0] IX_MCTL = 3'd4;
  localparam logic [2:0] IX_LSTAT = 3'd5;
  localparam logic [2:0] IX_MSTAT = 3'd6;
  localparam logic [2:0] IX_SCRATCH = 3'd7;

  localparam logic [7:0] IDENT_NONE = 8'h01;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (divisor != '0) && (cnt_q >= divisor - DIV_W'(1));
  assign tick = wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (divisor == '0)  cnt_d = '0;
    else if (wrap)      cnt_d = '0;
    else                cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load_en,
  input  logic [7:0] load_byte,
  output logic       txd,
  output logic       hold_empty,
  output logic       all_empty,
  output logic       active
);
  localparam int TCW = $clog2(OVERSAMPLE);
  localparam int FRAME_BITS = 10;

  logic [7:0]     hold_q, hold_d;
  logic           full_q, full_d;
  logic           act_q, act_d;
  logic [9:0]     sh_q, sh_d;
  logic [3:0]     bcnt_q, bcnt_d;
  logic [TCW-1:0] tcnt_q, tcnt_d;

  always_comb begin
    hold_d = hold_q;
    full_d = full_q;
    act_d  = act_q;
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    tcnt_d = tcnt_q;
    if (!act_q && full_q) begin
      act_d  = 1'b1;
      sh_d   = {1'b1, hold_q, 1'b0};
      bcnt_d = '0;
      tcnt_d = '0;
      full_d = 1'b0;
    end else if (act_q && tick) begin
      if (tcnt_q == TCW'(OVERSAMPLE - 1)) begin
        tcnt_d = '0;
        sh_d   = {1'b1, sh_q[9:1]};
        if (bcnt_q == 4'(FRAME_BITS - 1)) act_d = 1'b0;
        else                               bcnt_d = bcnt_q + 4'd1;
      end else begin
        tcnt_d = tcnt_q + TCW'(1);
      end
    end
    if (load_en) begin
      hold_d = load_byte;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      act_q  <= 1'b0;
      sh_q   <= '1;
      bcnt_q <= '0;
      tcnt_q <= '0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      act_q  <= act_d;
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign txd        = act_q ? sh_q[0] : 1'b1;
  assign hold_empty = !full_q;
  assign all_empty  = !full_q && !act_q;
  assign active     = act_q;
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_lite_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       frame_err,
  output logic       brk
);
  localparam int TCW = $clog2(OVERSAMPLE);
  localparam int MID = OVERSAMPLE / 2 - 1;

  logic [2:0]     sync_q;
  rx_state_e      st_q, st_d;
  logic [TCW-1:0] tcnt_q, tcnt_d;
  logic [2:0]     bcnt_q, bcnt_d;
  logic [7:0]     sh_q, sh_d;
  logic           done_q, done_d;
  logic           ferr_q, ferr_d;
  logic           brk_q, brk_d;
  logic           line, fall;

  assign line = sync_q[1];
  assign fall = sync_q[2] && !sync_q[1];

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    ferr_d = ferr_q;
    brk_d  = brk_q;
    unique case (st_q)
      RX_IDLE: begin
        if (fall) begin
          st_d   = RX_START;
          tcnt_d = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (tcnt_q == TCW'(MID)) begin
            tcnt_d = '0;
            bcnt_d = '0;
            st_d   = line ? RX_IDLE : RX_DATA;
          end else begin
            tcnt_d = tcnt_q + TCW'(1);
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (tcnt_q == TCW'(OVERSAMPLE - 1)) begin
            tcnt_d = '0;
            sh_d   = {line, sh_q[7:1]};
            if (bcnt_q == 3'd7) st_d = RX_STOP;
            else                bcnt_d = bcnt_q + 3'd1;
          end else begin
            tcnt_d = tcnt_q + TCW'(1);
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (tcnt_q == TCW'(OVERSAMPLE - 1)) begin
            tcnt_d = '0;
            done_d = 1'b1;
            ferr_d = !line;
            brk_d  = !line && (sh_q == 8'h00);
            st_d   = RX_IDLE;
          end else begin
            tcnt_d = tcnt_q + TCW'(1);
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], rxd};
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      ferr_q <= ferr_d;
      brk_q  <= brk_d;
    end
  end

  assign done      = done_q;
  assign rx_byte   = sh_q;
  assign frame_err = ferr_q;
  assign brk       = brk_q;
endmodule

// File: rtl/uart_lite.sv
module uart_lite
  import uart_lite_pkg::*;
#(
  parameter int REG_SHIFT  = 2,
  parameter int ADDR_W     = 3 + REG_SHIFT,
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              rxd,
  output logic              txd
);
  localparam int HI_W = DIV_W - 8;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [2:0] idx;
  logic       bank;
  assign idx = addr[REG_SHIFT +: 3];

  logic [7:0]      lctl_q, lctl_d;
  logic [7:0]      ien_q, ien_d;
  logic [7:0]      dlo_q, dlo_d;
  logic [HI_W-1:0] dhi_q, dhi_d;
  logic [7:0]      scr, scr_d;
  logic [7:0]      rbuf_q, rbuf_d;
  logic            dr, dr_d;
  logic            oe, oe_d;
  logic            fe, fe_d;
  logic            bi, bi_d;
  logic [7:0]      rd_q, rd_d;

  assign bank = lctl_q[7];

  logic [DIV_W-1:0] divisor;
  logic             baud_tick;
  logic             wr_thr, wr_scr, rd_lsr, rd_rbr;
  logic             thre, temt, tx_active;
  logic             rx_done, rx_ferr, rx_brk;
  logic [7:0]       rx_byte;
  logic [7:0]       lsr_val;

  assign divisor = {dhi_q, dlo_q};
  assign wr_thr  = wr_en && (idx == IX_DATA) && !bank;
  assign wr_scr  = wr_en && (idx == IX_SCRATCH);
  assign rd_lsr  = rd_en && (idx == IX_LSTAT);
  assign rd_rbr  = rd_en && (idx == IX_DATA) && !bank;
  assign lsr_val = {1'b0, temt, thre, bi, fe, 1'b0, oe, dr};

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .divisor (divisor),
    .tick    (baud_tick)
  );

  uart_tx_ser #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (baud_tick),
    .load_en    (wr_thr),
    .load_byte  (wr_data),
    .txd        (txd),
    .hold_empty (thre),
    .all_empty  (temt),
    .active     (tx_active)
  );

  uart_rx_deser #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (baud_tick),
    .rxd       (rxd),
    .done      (rx_done),
    .rx_byte   (rx_byte),
    .frame_err (rx_ferr),
    .brk       (rx_brk)
  );

  always_comb begin
    lctl_d = lctl_q;
    ien_d  = ien_q;
    dlo_d  = dlo_q;
    dhi_d  = dhi_q;
    scr_d  = scr;
    if (wr_en) begin
      unique case (idx)
        IX_DATA:    if (bank) dlo_d = wr_data;
        IX_IEN:     if (bank) dhi_d = wr_data[HI_W-1:0];
                    else      ien_d = wr_data;
        IX_LCTL:    lctl_d = wr_data;
        IX_SCRATCH: scr_d  = wr_data;
        default:    ;
      endcase
    end
  end

  always_comb begin
    rbuf_d = rbuf_q;
    dr_d   = dr;
    oe_d   = oe;
    fe_d   = fe;
    bi_d   = bi;
    if (rd_rbr) dr_d = 1'b0;
    if (rd_lsr) begin
      oe_d = 1'b0;
      fe_d = 1'b0;
      bi_d = 1'b0;
    end
    if (rx_done) begin
      rbuf_d = rx_byte;
      dr_d   = 1'b1;
      if (dr && !rd_rbr) oe_d = 1'b1;
      if (rx_ferr)       fe_d = 1'b1;
      if (rx_brk)        bi_d = 1'b1;
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      unique case (idx)
        IX_DATA:    rd_d = bank ? dlo_q : rbuf_q;
        IX_IEN:     rd_d = bank ? 8'(dhi_q) : ien_q;
        IX_IDENT:   rd_d = IDENT_NONE;
        IX_LCTL:    rd_d = lctl_q;
        IX_LSTAT:   rd_d = lsr_val;
        IX_SCRATCH: rd_d = scr;
        default:    rd_d = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lctl_q <= '0;
      ien_q  <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      scr    <= '0;
      rbuf_q <= '0;
      dr     <= 1'b0;
      oe     <= 1'b0;
      fe     <= 1'b0;
      bi     <= 1'b0;
      rd_q   <= '0;
    end else begin
      lctl_q <= lctl_d;
      ien_q  <= ien_d;
      dlo_q  <= dlo_d;
      dhi_q  <= dhi_d;
      scr    <= scr_d;
      rbuf_q <= rbuf_d;
      dr     <= dr_d;
      oe     <= oe_d;
      fe     <= fe_d;
      bi     <= bi_d;
      rd_q   <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/uart_lite_checks.sv
module uart_lite_checks #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [DIV_W-1:0] divisor,
  input logic             baud_tick,
  input logic             txd,
  input logic             tx_active,
  input logic             thre,
  input logic             temt,
  input logic             rx_done,
  input logic             rd_lsr,
  input logic             dr,
  input logic             oe,
  input logic             fe,
  input logic             bi,
  input logic             wr_scr,
  input logic [7:0]       scr
);
  AST_ZERO_DIV_NO_TICK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (divisor == '0) |-> !baud_tick); // R4
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_active |-> txd); // R5
  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    temt |-> thre); // R6
  AST_RX_SETS_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_done |=> dr); // R7
  AST_LSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_lsr && !rx_done) |=> (!oe && !fe && !bi)); // R10
  AST_SCRATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_scr |=> $stable(scr)); // R11
endmodule

bind uart_lite uart_lite_checks #(.DIV_W(DIV_W)) u_checks (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .divisor    (divisor),
  .baud_tick  (baud_tick),
  .txd        (txd),
  .tx_active  (tx_active),
  .thre       (thre),
  .temt       (temt),
  .rx_done    (rx_done),
  .rd_lsr     (rd_lsr),
  .dr         (dr),
  .oe         (oe),
  .fe         (fe),
  .bi         (bi),
  .wr_scr     (wr_scr),
  .scr        (scr)
);

// File: tb/tb_uart_lite.sv
`timescale 1ns/1ps
module tb_uart_lite;
  localparam int RS = 2;
  localparam int AW = 3 + RS;
  localparam int BITC = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          rxd = 1'b1;
  logic          txd;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart_lite #(.REG_SHIFT(RS)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .rxd(rxd), .txd(txd)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ix, input logic [RS-1:0] lo, input logic [7:0] d);
    @(negedge clk);
    addr = {ix, lo}; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ix, input logic [RS-1:0] lo, output logic [7:0] v);
    @(negedge clk);
    addr = {ix, lo}; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic send(input logic [7:0] b, input logic stopv);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = stopv;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC + 8) @(negedge clk);
  endtask

  task automatic mon(output logic [7:0] b, output logic stopv, output logic startv);
    do @(negedge clk); while (txd !== 1'b0);
    repeat (16) @(negedge clk);
    startv = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      b[i] = txd;
    end
    repeat (BITC) @(negedge clk);
    stopv = txd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] b1, b2;
    logic s1, s2, t1, t2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state
    chk("R3 txd idle", {7'd0, txd}, 8'h01);
    rd(3'd5, 2'd0, v); chk("R3 lsr reset", v, 8'h60);
    rd(3'd3, 2'd0, v); chk("R3 lctl reset", v, 8'h00);
    rd(3'd1, 2'd0, v); chk("R3 ien reset", v, 8'h00);
    wr(3'd3, 2'd0, 8'h80);
    rd(3'd0, 2'd0, v); chk("R3 div lo reset", v, 8'h00);
    rd(3'd1, 2'd0, v); chk("R3 div hi reset", v, 8'h00);
    wr(3'd3, 2'd0, 8'h00);

    // R12 fixed reads and ignored writes
    rd(3'd2, 2'd0, v); chk("R12 ident", v, 8'h01);
    wr(3'd4, 2'd0, 8'hFF); wr(3'd2, 2'd0, 8'hC7); wr(3'd6, 2'd0, 8'hFF); wr(3'd5, 2'd0, 8'hFF);
    rd(3'd4, 2'd0, v); chk("R12 mctl", v, 8'h00);
    rd(3'd6, 2'd0, v); chk("R12 mstat", v, 8'h00);
    rd(3'd2, 2'd0, v); chk("R12 ident after fcr", v, 8'h01);
    rd(3'd5, 2'd0, v); chk("R12 lsr after write", v, 8'h60);

    // R11 scratch
    wr(3'd7, 2'd0, 8'hA5); rd(3'd7, 2'd0, v); chk("R11 scratch a5", v, 8'hA5);
    wr(3'd7, 2'd0, 8'h5A); rd(3'd7, 2'd0, v); chk("R11 scratch 5a", v, 8'h5A);
    rd(3'd3, 2'd0, v); chk("R11 lctl untouched", v, 8'h00);

    // R1 low address bits ignored
    wr(3'd7, 2'd3, 8'h3C); rd(3'd7, 2'd0, v); chk("R1 alias write", v, 8'h3C);
    rd(3'd7, 2'd2, v); chk("R1 alias read", v, 8'h3C);

    // R4 zero divisor: frame not received
    send(8'h96, 1'b1);
    rd(3'd5, 2'd0, v); chk("R4 no rx at div 0", v, 8'h60);

    // R2 banking
    wr(3'd3, 2'd0, 8'h80);
    wr(3'd0, 2'd0, 8'h02);
    wr(3'd1, 2'd0, 8'h00);
    rd(3'd0, 2'd0, v); chk("R2 div lo", v, 8'h02);
    rd(3'd1, 2'd0, v); chk("R2 div hi", v, 8'h00);
    rd(3'd3, 2'd0, v); chk("R2 lctl", v, 8'h80);
    wr(3'd3, 2'd0, 8'h03);
    rd(3'd1, 2'd0, v); chk("R2 ien not div", v, 8'h00);
    wr(3'd1, 2'd0, 8'h0F);
    rd(3'd1, 2'd0, v); chk("R2 ien stored", v, 8'h0F);
    wr(3'd3, 2'd0, 8'h83);
    rd(3'd1, 2'd0, v); chk("R2 hi banked", v, 8'h00);
    rd(3'd0, 2'd0, v); chk("R2 lo banked", v, 8'h02);
    wr(3'd3, 2'd0, 8'h03);
    rd(3'd5, 2'd0, v); chk("R2 no tx from banked write", v, 8'h60);
    chk("R2 txd idle", {7'd0, txd}, 8'h01);
    rd(3'd0, 2'd0, v); chk("R4 stale start aborted", v, 8'h00);

    // R5 R6 transmit
    exp_q.push_back(8'h5A); exp_q.push_back(8'hA1);
    fork
      begin
        mon(b1, s1, t1);
        mon(b2, s2, t2);
      end
      begin
        wr(3'd0, 2'd0, 8'h5A);
        repeat (60) @(negedge clk);
        rd(3'd5, 2'd0, v); chk("R6 shifting hold empty", v, 8'h20);
        wr(3'd0, 2'd0, 8'hA1);
        rd(3'd5, 2'd0, v); chk("R6 hold full", v, 8'h00);
      end
    join
    chk("R5 start bit 1", {7'd0, t1}, 8'h00);
    chk("R5 R4 frame 1", b1, exp_q.pop_front());
    chk("R5 stop bit 1", {7'd0, s1}, 8'h01);
    chk("R5 start bit 2", {7'd0, t2}, 8'h00);
    chk("R5 R4 frame 2", b2, exp_q.pop_front());
    chk("R5 stop bit 2", {7'd0, s2}, 8'h01);
    repeat (40) @(negedge clk);
    rd(3'd5, 2'd0, v); chk("R6 all empty", v, 8'h60);
    chk("R5 idle high", {7'd0, txd}, 8'h01);

    // R7 receive
    send(8'hC3, 1'b1);
    rd(3'd5, 2'd0, v); chk("R7 ready", v, 8'h61);
    rd(3'd0, 2'd0, v); chk("R7 data", v, 8'hC3);
    rd(3'd5, 2'd0, v); chk("R7 ready cleared", v, 8'h60);

    // R8 overrun, R10 clear on status read
    send(8'h11, 1'b1);
    send(8'h7E, 1'b1);
    rd(3'd5, 2'd0, v); chk("R8 overrun", v, 8'h63);
    rd(3'd5, 2'd0, v); chk("R10 overrun cleared", v, 8'h61);
    rd(3'd0, 2'd0, v); chk("R8 newest byte", v, 8'h7E);

    // R9 framing
    send(8'h3C, 1'b0);
    rd(3'd5, 2'd0, v); chk("R9 framing", v, 8'h69);
    rd(3'd5, 2'd0, v); chk("R10 framing cleared", v, 8'h61);
    rd(3'd0, 2'd0, v); chk("R9 framing data", v, 8'h3C);

    // R9 break
    send(8'h00, 1'b0);
    rd(3'd5, 2'd0, v); chk("R9 break", v, 8'h79);
    rd(3'd5, 2'd0, v); chk("R10 break cleared", v, 8'h61);
    rd(3'd0, 2'd0, v); chk("R9 break data", v, 8'h00);
    rd(3'd5, 2'd0, v); chk("R7 final status", v, 8'h60);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule